// File: doc/BRIEF.md
# Byte-Lane Parallel Converter Bus Master

This block sits on the host side of a parallel sampling converter and runs its bus: an active-low chip select, separate active-low read and write strobes, a lane-select line that picks the high byte (high while the upper byte is moved), and a shared data bus that is either 8 or 12 lines wide. The bidirectional bus is split into `bus_out`, `bus_oe` and `bus_in` for the pad ring. A command port takes one of three operations: fetch the conversion result, write a 16-bit register word, or run the recovery sequence. The recovery sequence writes the fixed word 0x4002, which returns the device's test register to its default.

Each command becomes one or two byte cycles. A byte cycle is made of setup, strobe-low, hold and, between the two byte cycles, a gap. Every one of these lengths is a clock-count input. On a 12-bit bus a read finishes in one cycle. On an 8-bit bus a read takes two cycles, and the lane order is chosen by a configuration bit. The 16-bit result comes back with a one-clock done pulse.

Top module: `adc_bytelane_master`

## Requirements
- R1: In a byte cycle, chip select and the one strobe that matches the operation (read strobe for reads, write strobe for writes) go low together and stay low for exactly `cfg_strobe`+1 clocks. The other strobe stays high, and the two strobes are never low at the same time.
- R2: `adc_hben` = 0 selects the low lane and `adc_hben` = 1 selects the high byte. The line holds its value through every clock in which chip select is low. Between commands it keeps its last value.
- R3: When `cfg_wide`=1 (12-bit bus), a read is one byte cycle with `adc_hben`=0, and the result is {4'h0, bus_in[11:0]}. When `cfg_wide`=0 (8-bit bus), a read is two byte cycles. The result is {high-lane bus_in[7:0], low-lane bus_in[7:0]}, and bus_in[11:8] is ignored.
- R4: On an 8-bit bus, `cfg_hi_first`=0 reads the low lane first and `cfg_hi_first`=1 reads the high lane first. A 12-bit read ignores this bit.
- R5: Read data is the value on `bus_in` during the last strobe-low clock, which is the clock edge at which the read strobe rises.
- R6: A write (`req_op`=1) is two byte cycles. The first carries the low byte with `adc_hben`=0, and the second carries the high byte with `adc_hben`=1. The byte sits on bus_out[7:0], the upper bus lines read 0, and it is driven through setup, strobe and hold.
- R7: `req_op`=2 or 3 runs recovery: a write of 16'h4002 in the same two byte cycles as R6. `req_op`=0 is a read.
- R8: `bus_oe` is high only during the setup, strobe and hold clocks of a write. A write that follows a read first waits max(`cfg_turn`,1) clocks with the bus released and chip select high.
- R9: Setup lasts `cfg_setup` clocks, hold lasts `cfg_hold` clocks, and the gap between two byte cycles lasts `cfg_gap` clocks. Each may be zero. If setup, hold and gap are all zero, a single one-clock gap is inserted so that the strobe rises between the byte cycles.
- R10: `req_ready` is high exactly when no command is in progress. A command is taken on a clock edge with `req_valid` and `req_ready` both high; requests made while busy are ignored.
- R11: `done` is high for exactly one clock: the clock right after the last strobe or hold clock of a command. In that clock `done_rdata` holds the read result, or 0 after a write or recovery.
- R12: While reset is held, chip select and both strobes are high, `bus_oe`=0, `adc_hben`=0, `done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wide | input | 1 | 1: 12-bit bus, reads take one cycle |
| cfg_hi_first | input | 1 | 1: 8-bit reads take the high lane first |
| cfg_setup | input | CW | Setup clocks before each strobe |
| cfg_strobe | input | CW | Strobe-low clocks minus one |
| cfg_hold | input | CW | Hold clocks after each strobe |
| cfg_gap | input | CW | Gap clocks between two byte cycles |
| cfg_turn | input | CW | Bus turnaround clocks before a write that follows a read (minimum 1) |
| req_valid | input | 1 | Command request |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 recovery |
| req_wdata | input | 16 | Word to write |
| req_ready | output | 1 | Idle, command can be taken |
| done | output | 1 | One-clock completion pulse |
| done_rdata | output | 16 | Read result while done is high |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_hben | output | 1 | High-byte lane select |
| bus_oe | output | 1 | Host drives the data bus |
| bus_out | output | DW | Data driven onto the bus |
| bus_in | input | DW | Data sampled from the bus |

## Verification
Pin activity starts in the clock right after the accepting edge, so the first setup, turnaround or strobe clock is due one cycle after `req_valid` is sampled with `req_ready`. The pulse on `done` is due in the clock after the final strobe or hold clock. The bench works out the whole pin trace of each command from the configured counts at the falling edge before acceptance. It then pops one expected clock per falling edge and compares every output there, and shows idle values whenever its queue is empty. Because sampling is half a period away from the active edge, each result is checked in exactly the clock in which it is due.

// File: rtl/adcbl_pkg.sv
package adcbl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_GAP
  } phase_e;

  localparam logic [15:0] RESTORE_WORD = 16'h4002;

  // Lane of byte cycle idx: writes low then high; 12-bit reads use the
  // low lane only; 8-bit reads start from the lane picked by hi_first.
  function automatic logic lane_high(input logic is_wr, input logic wide,
                                     input logic hi_first, input logic idx);
    logic r;
    if (is_wr)      r = idx;
    else if (wide)  r = 1'b0;
    else            r = idx ^ hi_first;
    return r;
  endfunction

  // Merge one lane sample into the word being assembled.
  function automatic logic [15:0] merge_lane(input logic [15:0] acc,
                                             input logic [11:0] lanes,
                                             input logic hi, input logic wide);
    logic [15:0] r;
    r = acc;
    if (hi)        r[15:8] = lanes[7:0];
    else if (wide) r = {4'h0, lanes};
    else           r[7:0] = lanes[7:0];
    return r;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

endpackage

// File: rtl/adcbl_seq.sv
module adcbl_seq
  import adcbl_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          two_cycles,
  input  logic          need_turn,
  input  logic [CW-1:0] setup_len,
  input  logic [CW-1:0] strobe_len,
  input  logic [CW-1:0] hold_len,
  input  logic [CW-1:0] gap_len,
  input  logic [CW-1:0] turn_len,
  output phase_e        phase,
  output logic          byte_idx,
  output logic          strobe_last,
  output logic          seq_end
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt, cnt_ld;
  phase_e        ph_nx, lead_ph;
  logic          idx_nx, load;

  assign lead_ph     = (setup_len != '0) ? PH_SETUP : PH_STROBE;
  assign strobe_last = (phase == PH_STROBE) && (cnt == '0);

  always_comb begin
    ph_nx   = phase;
    idx_nx  = byte_idx;
    load    = 1'b0;
    seq_end = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        load   = 1'b1;
        idx_nx = 1'b0;
        ph_nx  = need_turn ? PH_TURN : lead_ph;
      end
      PH_TURN, PH_SETUP, PH_GAP: if (cnt == '0) begin
        load  = 1'b1;
        ph_nx = (phase == PH_SETUP) ? PH_STROBE : lead_ph;
      end
      PH_STROBE, PH_HOLD: if (cnt == '0) begin
        load = 1'b1;
        if (phase == PH_STROBE && hold_len != '0) begin
          ph_nx = PH_HOLD;
        end else if (!two_cycles || byte_idx) begin
          ph_nx   = PH_IDLE;
          seq_end = 1'b1;
        end else begin
          idx_nx = 1'b1;
          // a strobe must rise between byte cycles: force one gap clock
          ph_nx  = (gap_len != '0 || (phase == PH_STROBE && setup_len == '0))
                   ? PH_GAP : lead_ph;
        end
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (ph_nx)
      PH_TURN:   cnt_ld = (turn_len == '0) ? '0 : turn_len - ONE;
      PH_SETUP:  cnt_ld = setup_len - ONE;
      PH_STROBE: cnt_ld = strobe_len;
      PH_HOLD:   cnt_ld = hold_len - ONE;
      PH_GAP:    cnt_ld = (gap_len == '0) ? '0 : gap_len - ONE;
      default:   cnt_ld = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      byte_idx <= 1'b0;
    end else begin
      phase    <= ph_nx;
      byte_idx <= idx_nx;
      if (load)             cnt <= cnt_ld;
      else if (cnt != '0)   cnt <= cnt - ONE;
    end
  end

endmodule

// File: rtl/adcbl_pins.sv
module adcbl_pins
  import adcbl_pkg::*;
#(
  parameter int DW = 12
) (
  input  phase_e        phase,
  input  logic          is_wr,
  input  logic          hi,
  input  logic [15:0]   word,
  output logic          cs_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          hben,
  output logic          oe,
  output logic [DW-1:0] bus_out
);

  logic active, drive;

  assign active  = (phase == PH_STROBE);
  assign drive   = is_wr && (phase == PH_SETUP || phase == PH_STROBE || phase == PH_HOLD);
  assign cs_n    = !active;
  assign rd_n    = !(active && !is_wr);
  assign wr_n    = !(active && is_wr);
  assign hben    = hi;
  assign oe      = drive;
  assign bus_out = drive ? DW'(pick_byte(word, hi)) : '0;

endmodule

// File: rtl/adcbl_capture.sv
module adcbl_capture
  import adcbl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        take,
  input  logic        hi,
  input  logic        wide,
  input  logic [11:0] lanes,
  output logic [15:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (clear) word <= '0;
    else if (take)  word <= merge_lane(word, lanes, hi, wide);
  end

endmodule

// File: rtl/adc_bytelane_master.sv
module adc_bytelane_master
  import adcbl_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wide,
  input  logic          cfg_hi_first,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_strobe,
  input  logic [CW-1:0] cfg_hold,
  input  logic [CW-1:0] cfg_gap,
  input  logic [CW-1:0] cfg_turn,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [15:0]   req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [15:0]   done_rdata,
  output logic          adc_cs_n,
  output logic          adc_rd_n,
  output logic          adc_wr_n,
  output logic          adc_hben,
  output logic          bus_oe,
  output logic [DW-1:0] bus_out,
  input  logic [DW-1:0] bus_in
);

  localparam bit WIDE_OK = (DW >= 12);

  logic        wide_sel;
  logic [11:0] lanes_in;

  generate
    if (WIDE_OK) begin : g_wide
      assign wide_sel = cfg_wide;
      assign lanes_in = bus_in[11:0];
    end else begin : g_narrow
      assign wide_sel = 1'b0;
      assign lanes_in = {{(12-DW){1'b0}}, bus_in};
    end
  endgenerate

  phase_e      phase;
  logic        byte_idx, strobe_last, seq_end;
  logic        accept, need_turn, two_cycles, hi;
  logic        op_wr, op_wide, op_hi_first, last_rd, done_r;
  logic [15:0] op_word, cap_word;

  assign req_ready  = (phase == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign need_turn  = (req_op != 2'd0) && last_rd;
  assign two_cycles = op_wr || !op_wide;
  assign hi         = lane_high(op_wr, op_wide, op_hi_first, byte_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr       <= 1'b0;
      op_wide     <= 1'b0;
      op_hi_first <= 1'b0;
      op_word     <= '0;
      last_rd     <= 1'b0;
      done_r      <= 1'b0;
    end else begin
      done_r <= seq_end;
      if (accept) begin
        op_wr       <= (req_op != 2'd0);
        op_wide     <= wide_sel;
        op_hi_first <= cfg_hi_first;
        op_word     <= req_op[1] ? RESTORE_WORD : req_wdata;
      end
      if (seq_end) last_rd <= !op_wr;
    end
  end

  adcbl_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .two_cycles (two_cycles),
    .need_turn  (need_turn),
    .setup_len  (cfg_setup),
    .strobe_len (cfg_strobe),
    .hold_len   (cfg_hold),
    .gap_len    (cfg_gap),
    .turn_len   (cfg_turn),
    .phase      (phase),
    .byte_idx   (byte_idx),
    .strobe_last(strobe_last),
    .seq_end    (seq_end)
  );

  adcbl_pins #(.DW(DW)) u_pins (
    .phase  (phase),
    .is_wr  (op_wr),
    .hi     (hi),
    .word   (op_word),
    .cs_n   (adc_cs_n),
    .rd_n   (adc_rd_n),
    .wr_n   (adc_wr_n),
    .hben   (adc_hben),
    .oe     (bus_oe),
    .bus_out(bus_out)
  );

  adcbl_capture u_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(accept),
    .take (strobe_last && !op_wr),
    .hi   (hi),
    .wide (op_wide),
    .lanes(lanes_in),
    .word (cap_word)
  );

  assign done       = done_r;
  assign done_rdata = done_r ? cap_word : 16'h0000;

endmodule

// File: rtl/adcbl_checker.sv
module adcbl_checker #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          hben,
  input logic          oe,
  input logic [DW-1:0] bus_out,
  input logic          done,
  input logic          ready
);

  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r1_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !cs_n);

  a_r2_lane_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(hben));

  a_r6_upper_lines_zero: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> ((bus_out >> 8) == '0));

  a_r8_no_drive_reading: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !oe);

  a_r8_release_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> !oe);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

endmodule

bind adc_bytelane_master adcbl_checker #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (adc_cs_n),
  .rd_n   (adc_rd_n),
  .wr_n   (adc_wr_n),
  .hben   (adc_hben),
  .oe     (bus_oe),
  .bus_out(bus_out),
  .done   (done),
  .ready  (req_ready)
);

// File: tb/sim_adc_bytelane_master.sv
module sim_adc_bytelane_master;

  localparam int DW = 12;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          wide = 1'b0, hi_first = 1'b0;
  logic [CW-1:0] s_len = 8'd1, t_len = 8'd2, h_len = 8'd1, g_len = 8'd2, u_len = 8'd0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [15:0]   req_wdata = 16'h0;
  logic          req_ready, done;
  logic [15:0]   done_rdata;
  logic          adc_cs_n, adc_rd_n, adc_wr_n, adc_hben, bus_oe;
  logic [DW-1:0] bus_out, bus_in;
  logic [15:0]   dev = 16'h0;

  // behavioural converter: drives only while selected and read-strobed
  assign bus_in = (!adc_cs_n && !adc_rd_n)
                  ? (adc_hben ? {4'hC, dev[15:8]}
                              : (wide ? dev[11:0] : {~dev[11:8], dev[7:0]}))
                  : 12'h5A5;

  adc_bytelane_master #(.DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wide(wide), .cfg_hi_first(hi_first),
    .cfg_setup(s_len), .cfg_strobe(t_len), .cfg_hold(h_len), .cfg_gap(g_len),
    .cfg_turn(u_len), .req_valid(req_valid), .req_op(req_op), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .done_rdata(done_rdata),
    .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_wr_n(adc_wr_n), .adc_hben(adc_hben),
    .bus_oe(bus_oe), .bus_out(bus_out), .bus_in(bus_in)
  );

  typedef struct packed {
    logic        cs_n, rd_n, wr_n, hben, oe;
    logic [11:0] bus;
    logic        dn;
    logic [15:0] rdata;
    logic        rdy;
  } exp_t;

  exp_t  q[$];
  int    n_checks = 0, n_fail = 0;
  logic  m_hben = 1'b0, m_last_rd = 1'b0, took = 1'b0, halt = 1'b0;
  string cur = "reset";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s (%s) actual=%0h expected=%0h", tag, what, cur, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic cs, input logic rd, input logic wr,
                              input logic hb, input logic oe, input logic [11:0] bus,
                              input logic dn, input logic [15:0] rdat, input logic rdy);
    exp_t e;
    e.cs_n = cs; e.rd_n = rd; e.wr_n = wr; e.hben = hb; e.oe = oe;
    e.bus = bus; e.dn = dn; e.rdata = rdat; e.rdy = rdy;
    return e;
  endfunction

  // Lane per byte: writes low then high; 12-bit read low only; 8-bit read
  // starts from the lane chosen by hi_first (R4).
  function automatic logic lane_of(input bit wr, input int b);
    if (wr) return b[0];
    if (wide) return 1'b0;
    return b[0] ^ hi_first;
  endfunction

  task automatic plan(input logic [1:0] op, input logic [15:0] wd);
    bit          wr = (op != 2'd0);
    logic [15:0] word = op[1] ? 16'h4002 : wd;  // R7
    int          n = (wr || !wide) ? 2 : 1;
    logic [15:0] rexp = wide ? {4'h0, dev[11:0]} : dev;
    logic        h;
    logic [11:0] byt;
    if (wr && m_last_rd) begin
      for (int i = 0; i < ((u_len == 0) ? 1 : int'(u_len)); i++)
        q.push_back(mk(1, 1, 1, lane_of(wr, 0), 0, 12'h0, 0, 16'h0, 0));
    end
    for (int b = 0; b < n; b++) begin
      h   = lane_of(wr, b);
      byt = wr ? {4'h0, (h ? word[15:8] : word[7:0])} : 12'h0;
      for (int i = 0; i < int'(s_len); i++) q.push_back(mk(1, 1, 1, h, wr, byt, 0, 16'h0, 0));
      for (int i = 0; i <= int'(t_len); i++) q.push_back(mk(0, wr, !wr, h, wr, byt, 0, 16'h0, 0));
      for (int i = 0; i < int'(h_len); i++) q.push_back(mk(1, 1, 1, h, wr, byt, 0, 16'h0, 0));
      if (b < n - 1) begin
        int g = (g_len == 0 && s_len == 0 && h_len == 0) ? 1 : int'(g_len);  // R9
        for (int i = 0; i < g; i++)
          q.push_back(mk(1, 1, 1, lane_of(wr, b + 1), 0, 12'h0, 0, 16'h0, 0));
      end
    end
    q.push_back(mk(1, 1, 1, lane_of(wr, n - 1), 0, 12'h0, 1, wr ? 16'h0 : rexp, 1));
    m_hben    = lane_of(wr, n - 1);
    m_last_rd = !wr;
  endtask

  always @(negedge clk) begin
    if (rst_n && !halt) begin
      exp_t e;
      if (q.size() != 0) e = q.pop_front();
      else e = mk(1, 1, 1, m_hben, 0, 12'h0, 0, 16'h0, 1);
      chk(adc_cs_n === e.cs_n, "R1", "cs_n", adc_cs_n, e.cs_n);
      chk(adc_rd_n === e.rd_n, "R1", "rd_n", adc_rd_n, e.rd_n);
      chk(adc_wr_n === e.wr_n, "R1", "wr_n", adc_wr_n, e.wr_n);
      chk(adc_hben === e.hben, "R2", "hben", adc_hben, e.hben);
      chk(bus_oe === e.oe, "R8", "bus_oe", bus_oe, e.oe);
      chk(bus_out === e.bus, "R6", "bus_out", bus_out, e.bus);
      chk(req_ready === e.rdy, "R10", "req_ready", req_ready, e.rdy);
      chk(done === e.dn, "R11", "done", done, e.dn);
      if (e.dn) chk(done_rdata === e.rdata, "R3", "done_rdata", done_rdata, e.rdata);
      if (q.size() == 0 && req_valid) begin
        plan(req_op, req_wdata);
        took = 1'b1;
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [15:0] wd);
    @(posedge clk); #1;
    req_op = op; req_wdata = wd; took = 1'b0; req_valid = 1'b1;
    do @(posedge clk); while (!took);
    #1 req_valid = 1'b0;
    while (q.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic timing(input int s, input int t, input int h, input int g, input int u);
    s_len = CW'(s); t_len = CW'(t); h_len = CW'(h); g_len = CW'(g); u_len = CW'(u);
  endtask

  task automatic finish_run;
    halt = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired (%s)", cur);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur = "R12 reset state";
    chk(adc_cs_n === 1'b1 && adc_rd_n === 1'b1 && adc_wr_n === 1'b1, "R12", "strobes",
        {adc_cs_n, adc_rd_n, adc_wr_n}, 3'b111);
    chk(bus_oe === 1'b0, "R12", "bus_oe", bus_oe, 0);
    chk(adc_hben === 1'b0, "R12", "hben", adc_hben, 0);
    chk(done === 1'b0, "R12", "done", done, 0);
    chk(req_ready === 1'b1, "R12", "req_ready", req_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    cur = "R3 R5 8-bit read, low lane first";
    wide = 0; hi_first = 0; timing(1, 2, 1, 2, 0); dev = 16'h3CA7;
    issue(2'd0, 16'h0);

    cur = "R4 8-bit read, high lane first";
    hi_first = 1; dev = 16'hE15B;
    issue(2'd0, 16'h0);

    cur = "R3 12-bit read, single cycle, hi_first ignored";
    wide = 1; dev = 16'h7ABC;
    issue(2'd0, 16'h0);

    cur = "R6 R8 write after read, turnaround 0 forced to 1";
    issue(2'd1, 16'hBEEF);

    cur = "R8 write after read, turnaround 3";
    wide = 0; hi_first = 0; timing(2, 1, 2, 1, 3); dev = 16'h0F1E;
    issue(2'd0, 16'h0);
    issue(2'd1, 16'h1234);

    cur = "R7 recovery op 2 and op 3";
    issue(2'd2, 16'hFFFF);
    issue(2'd3, 16'h5555);

    cur = "R9 all timing counts zero";
    timing(0, 0, 0, 0, 0); dev = 16'h96C3;
    issue(2'd0, 16'h0);
    issue(2'd1, 16'hA55A);
    wide = 1;
    issue(2'd0, 16'h0);
    wide = 0; hi_first = 1;
    issue(2'd0, 16'h0);

    cur = "R9 gap only, no setup or hold";
    timing(0, 1, 0, 3, 1); hi_first = 0; dev = 16'h4411;
    issue(2'd1, 16'h8001);
    issue(2'd0, 16'h0);

    cur = "R10 request while busy ignored";
    timing(2, 4, 2, 3, 0); dev = 16'hC0DE;
    @(posedge clk); #1;
    req_op = 2'd0; took = 1'b0; req_valid = 1'b1;
    do @(posedge clk); while (!took);
    #1 req_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 req_op = 2'd1; req_wdata = 16'hDEAD; req_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1 req_valid = 1'b0;
    while (q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);

    finish_run();
  end

endmodule